// File: doc/BRIEF.md
# Load-Balancer Packet Header Filter

This block is the admission stage of a UDP load balancer. It receives Ethernet frames one byte per cycle and walks the Ethernet, IPv4 (options included) or IPv6, UDP and 12-byte load-balancer headers. Along the way it captures the destination MAC, the EtherType, the destination IP address and the load-balancer protocol and tick. The destination IP is held as a 128-bit key, with IPv4 addresses zero-extended. Once the header is complete, that key is matched against a small exact-match table. The payload that follows the header is never examined.

For each frame the block produces exactly one registered decision, either accept or drop. The decision carries the extracted fields, which later routing stages use. If a frame fails a header check, or ends before its header is complete, it is dropped as soon as that becomes known. The rest of the frame is then skipped.

Software fills the table through a one-cycle write strobe. Each write supplies an entry index, a valid bit and the key.

Top module: `lb_hdr_filter`

## Requirements
- R1: After reset no decision is issued and every table entry is invalid, so the first frames are dropped until entries are written.
- R2: The EtherType is the big-endian 16-bit field at frame bytes 12 and 13. The value 0x0800 selects the IPv4 path and 0x86DD selects the IPv6 path. Any other value drops the frame, and the decision follows frame byte 13.
- R3: On the IPv4 path, the high nibble of IP byte 0 must be 4 and the low nibble (the header length in 32-bit words) must be at least 5; otherwise the frame is dropped on that byte. Option bytes are skipped, so the UDP header starts at IP byte 4 times that length.
- R4: On the IPv6 path, the high nibble of IP byte 0 must be 6, otherwise the frame is dropped on that byte. The UDP header starts at IP byte 40.
- R5: The protocol number must be 17, otherwise the frame is dropped on that byte. For IPv4 it is at IP byte 9; for IPv6 it is the next-header field at IP byte 6.
- R6: The UDP destination port, at UDP bytes 2 and 3 in big-endian order, must be 0x4C42. Otherwise the frame is dropped at UDP byte 3.
- R7: In the load-balancer header, the big-endian magic at bytes 0 and 1 must be 0x4C42 (drop at byte 1). The version at byte 2 must be 1 (drop at byte 2). Byte 3 is the protocol field. Bytes 4 to 11 form the big-endian 64-bit tick.
- R8: A frame whose headers pass all checks is accepted only if a valid table entry matches exactly on three fields: the destination MAC (frame bytes 0 to 5), the EtherType, and the 128-bit IP key. The IP key is 96 zero bits followed by IPv4 bytes 16 to 19, or IPv6 bytes 24 to 39. A miss drops the frame.
- R9: A table write stores the key and the valid bit at the given index, and clearing the valid bit removes the entry. The write affects every decision registered after the write cycle.
- R10: Each frame yields exactly one decision, asserted one cycle after its deciding byte. The deciding byte is the one of these that occurs first: the last load-balancer header byte, the byte that reveals the first failed check, or the frame's last byte if the header is incomplete.
- R11: Bytes after a frame's decision, including payload, produce no further decision. The byte after the last-byte marker starts a new frame, and idle cycles between bytes are ignored.
- R12: Along with an accept, the block outputs the tick, the 128-bit IP key, the EtherType and the load-balancer protocol byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | A frame byte is present this cycle |
| byte_i | input | 8 | Frame byte |
| byte_last_i | input | 1 | Marks the frame's last byte |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | IDX_W (5) | Table entry index |
| cfg_en_i | input | 1 | Valid bit written to the entry |
| cfg_mac_i | input | 48 | Entry destination MAC |
| cfg_etype_i | input | 16 | Entry EtherType |
| cfg_ip_i | input | 128 | Entry 128-bit IP key |
| dec_vld_o | output | 1 | Decision strobe |
| dec_accept_o | output | 1 | Frame accepted |
| dec_tick_o | output | 64 | Load-balancer tick |
| dec_ip_o | output | 128 | Normalized destination IP |
| dec_etype_o | output | 16 | EtherType |
| dec_proto_o | output | 8 | Load-balancer protocol byte |

## Verification
Every decision is due on the cycle after its deciding byte. This holds whether that byte is the last header byte, the byte that fails a check, or a truncating last byte. The bench therefore compares the decision strobe on every clock, one step after each byte is driven, including idle cycles inserted between bytes. A behavioural model finds the deciding byte index and the expected result from the byte array alone, then flags that step. The bench checks the fields only on an accept. Table writes take effect for the next frame's decision, so no frame overlaps a write.

// File: rtl/lb_filt_pkg.sv
`timescale 1ns/1ps
package lb_filt_pkg;
  localparam logic [15:0] ET_IPV4 = 16'h0800;
  localparam logic [15:0] ET_IPV6 = 16'h86DD;
  localparam logic [7:0]  IP_UDP  = 8'd17;

  typedef enum logic [2:0] {
    PS_ETH, PS_IP4, PS_OPT, PS_IP6, PS_UDP, PS_LB, PS_SKIP
  } pstate_e;

  typedef struct packed {
    logic [47:0]  mac;
    logic [15:0]  etype;
    logic [127:0] ip;
  } flt_key_t;
endpackage

// File: rtl/lb_hdr_walk.sv
`timescale 1ns/1ps
module lb_hdr_walk
  import lb_filt_pkg::*;
#(
  parameter logic [15:0] UDP_PORT = 16'h4C42,
  parameter logic [15:0] MAGIC    = 16'h4C42,
  parameter logic [7:0]  VER      = 8'd1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        vld_i,
  input  logic [7:0]  byte_i,
  input  logic        last_i,
  output logic        done_o,
  output logic        ok_o,
  output flt_key_t    key_o,
  output logic [63:0] tick_o,
  output logic [7:0]  proto_o
);
  pstate_e      state_q, st_n;
  logic [5:0]   cnt_q, cnt_n, optlen_q;
  logic [7:0]   hold_q, proto_q;
  logic [47:0]  mac_q;
  logic [15:0]  et_q;
  logic [127:0] ip_q;
  logic [63:0]  tick_q;
  logic [15:0]  pair;
  logic         bad, fin;

  assign pair = {hold_q, byte_i};

  always_comb begin
    bad   = 1'b0;
    fin   = 1'b0;
    st_n  = state_q;
    cnt_n = cnt_q + 6'd1;
    unique case (state_q)
      PS_ETH: if (cnt_q == 6'd13) begin
        cnt_n = '0;
        if (pair == ET_IPV4)      st_n = PS_IP4;
        else if (pair == ET_IPV6) st_n = PS_IP6;
        else                      bad  = 1'b1;
      end
      PS_IP4: begin
        if (cnt_q == 6'd0 && (byte_i[7:4] != 4'h4 || byte_i[3:0] < 4'h5)) bad = 1'b1;
        if (cnt_q == 6'd9 && byte_i != IP_UDP) bad = 1'b1;
        if (cnt_q == 6'd19) begin
          cnt_n = '0;
          st_n  = (optlen_q == 6'd0) ? PS_UDP : PS_OPT;
        end
      end
      PS_OPT: if (cnt_q == optlen_q - 6'd1) begin
        cnt_n = '0;
        st_n  = PS_UDP;
      end
      PS_IP6: begin
        if (cnt_q == 6'd0 && byte_i[7:4] != 4'h6) bad = 1'b1;
        if (cnt_q == 6'd6 && byte_i != IP_UDP) bad = 1'b1;
        if (cnt_q == 6'd39) begin
          cnt_n = '0;
          st_n  = PS_UDP;
        end
      end
      PS_UDP: begin
        if (cnt_q == 6'd3 && pair != UDP_PORT) bad = 1'b1;
        if (cnt_q == 6'd7) begin
          cnt_n = '0;
          st_n  = PS_LB;
        end
      end
      PS_LB: begin
        if (cnt_q == 6'd1 && pair != MAGIC) bad = 1'b1;
        if (cnt_q == 6'd2 && byte_i != VER) bad = 1'b1;
        if (cnt_q == 6'd11) fin = 1'b1;
      end
      default: cnt_n = cnt_q;
    endcase
    if (last_i) begin
      st_n  = PS_ETH;
      cnt_n = '0;
    end else if (bad || fin) begin
      st_n  = PS_SKIP;
    end
  end

  assign done_o = vld_i & (bad | fin | (last_i & (state_q != PS_SKIP)));
  assign ok_o   = fin & ~bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PS_ETH;
      cnt_q    <= '0;
      optlen_q <= '0;
      hold_q   <= '0;
      proto_q  <= '0;
      mac_q    <= '0;
      et_q     <= '0;
      ip_q     <= '0;
      tick_q   <= '0;
    end else if (vld_i) begin
      state_q <= st_n;
      cnt_q   <= cnt_n;
      hold_q  <= byte_i;
      unique case (state_q)
        PS_ETH: begin
          if (cnt_q < 6'd6)   mac_q <= {mac_q[39:0], byte_i};
          if (cnt_q == 6'd0)  ip_q  <= '0;
          if (cnt_q >= 6'd12) et_q  <= {et_q[7:0], byte_i};
        end
        PS_IP4: begin
          if (cnt_q == 6'd0) optlen_q <= {byte_i[3:0] - 4'd5, 2'b00};
          if (cnt_q >= 6'd16) ip_q <= {ip_q[119:0], byte_i};
        end
        PS_IP6: if (cnt_q >= 6'd24) ip_q <= {ip_q[119:0], byte_i};
        PS_LB: begin
          if (cnt_q == 6'd3)  proto_q <= byte_i;
          if (cnt_q >= 6'd4)  tick_q  <= {tick_q[55:0], byte_i};
        end
        default: ;
      endcase
    end
  end

  assign key_o   = '{mac: mac_q, etype: et_q, ip: ip_q};
  assign tick_o  = {tick_q[55:0], byte_i};
  assign proto_o = proto_q;

  // R10: after a mid-frame decision the walker idles until frame end
  a_r10_skip_after_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !last_i) |=> (state_q == PS_SKIP));
  // R11: the byte after the last marker begins a new frame
  a_r11_frame_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && last_i) |=> (state_q == PS_ETH && cnt_q == 6'd0));
  // R3: option skipping only with a nonzero option length
  a_r3_opt_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_OPT) |-> (optlen_q != 6'd0 && cnt_q < optlen_q));
endmodule

// File: rtl/lb_key_table.sv
`timescale 1ns/1ps
module lb_key_table
  import lb_filt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             en_i,
  input  flt_key_t         wkey_i,
  input  flt_key_t         look_i,
  output logic             hit_o
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    flt_key_t key_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        key_q    <= '0;
      end else if (we_i && idx_i == IDX_W'(g)) begin
        vld_q[g] <= en_i;
        key_q    <= wkey_i;
      end
    end
    assign match[g] = vld_q[g] && (key_q == look_i);
  end

  assign hit_o = |match;

  // R9: a write lands in the addressed entry
  a_r9_write_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (vld_q[$past(idx_i)] == $past(en_i)));
  // R9: entries only change on a write
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(vld_q));
endmodule

// File: rtl/lb_hdr_filter.sv
`timescale 1ns/1ps
module lb_hdr_filter
  import lb_filt_pkg::*;
#(
  parameter int          TBL_DEPTH = 32,
  parameter int          IDX_W     = $clog2(TBL_DEPTH),
  parameter logic [15:0] UDP_PORT  = 16'h4C42,
  parameter logic [15:0] MAGIC     = 16'h4C42,
  parameter logic [7:0]  VER       = 8'd1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_last_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic             cfg_en_i,
  input  logic [47:0]      cfg_mac_i,
  input  logic [15:0]      cfg_etype_i,
  input  logic [127:0]     cfg_ip_i,
  output logic             dec_vld_o,
  output logic             dec_accept_o,
  output logic [63:0]      dec_tick_o,
  output logic [127:0]     dec_ip_o,
  output logic [15:0]      dec_etype_o,
  output logic [7:0]       dec_proto_o
);
  logic        done, ok, hit;
  flt_key_t    key, wkey;
  logic [63:0] tick_nxt;
  logic [7:0]  proto;

  lb_hdr_walk #(.UDP_PORT(UDP_PORT), .MAGIC(MAGIC), .VER(VER)) u_walk (
    .clk_i, .rst_ni,
    .vld_i   (byte_vld_i),
    .byte_i  (byte_i),
    .last_i  (byte_last_i),
    .done_o  (done),
    .ok_o    (ok),
    .key_o   (key),
    .tick_o  (tick_nxt),
    .proto_o (proto)
  );

  assign wkey = '{mac: cfg_mac_i, etype: cfg_etype_i, ip: cfg_ip_i};

  lb_key_table #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) u_tbl (
    .clk_i, .rst_ni,
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .en_i   (cfg_en_i),
    .wkey_i (wkey),
    .look_i (key),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_vld_o    <= 1'b0;
      dec_accept_o <= 1'b0;
      dec_tick_o   <= '0;
      dec_ip_o     <= '0;
      dec_etype_o  <= '0;
      dec_proto_o  <= '0;
    end else begin
      dec_vld_o <= done;
      if (done) begin
        dec_accept_o <= ok & hit;
        dec_tick_o   <= tick_nxt;
        dec_ip_o     <= key.ip;
        dec_etype_o  <= key.etype;
        dec_proto_o  <= proto;
      end else begin
        dec_accept_o <= 1'b0;
      end
    end
  end

  // R10: a decision always follows a presented byte
  a_r10_dec_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |-> $past(byte_vld_i));
  // R12: accept only travels with a decision
  a_r12_accept_in_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_accept_o |-> dec_vld_o);
  // R2: only IP EtherTypes are ever accepted
  a_r2_accept_etype: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_accept_o |-> (dec_etype_o == ET_IPV4 || dec_etype_o == ET_IPV6));
  // R8: accepted IPv4 keys are zero-extended
  a_r8_v4_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_accept_o && dec_etype_o == ET_IPV4) |-> (dec_ip_o[127:32] == '0));
endmodule

// File: tb/test_lb_hdr_filter.sv
`timescale 1ns/1ps
module test_lb_hdr_filter;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_vld = 0, byte_last = 0;
  logic [7:0] byte_d = '0;
  logic cfg_we = 0, cfg_en = 0;
  logic [4:0] cfg_idx = '0;
  logic [47:0] cfg_mac = '0;
  logic [15:0] cfg_et = '0;
  logic [127:0] cfg_ip = '0;
  logic dec_vld, dec_acc;
  logic [63:0] dec_tick;
  logic [127:0] dec_ip;
  logic [15:0] dec_et;
  logic [7:0] dec_proto;

  always #5 clk = ~clk;

  lb_hdr_filter i_lb_hdr_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .byte_vld_i(byte_vld), .byte_i(byte_d), .byte_last_i(byte_last),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en),
    .cfg_mac_i(cfg_mac), .cfg_etype_i(cfg_et), .cfg_ip_i(cfg_ip),
    .dec_vld_o(dec_vld), .dec_accept_o(dec_acc), .dec_tick_o(dec_tick),
    .dec_ip_o(dec_ip), .dec_etype_o(dec_et), .dec_proto_o(dec_proto)
  );

  int n_cmp = 0, n_bad = 0, gap_ctr = 0;

  // behavioural table image
  bit           t_vld [32];
  logic [47:0]  t_mac [32];
  logic [15:0]  t_et  [32];
  logic [127:0] t_ip  [32];

  // model results
  int           m_idx;
  bit           m_acc;
  logic [63:0]  m_tick;
  logic [127:0] m_ip;
  logic [15:0]  m_et;
  logic [7:0]   m_proto;

  localparam logic [47:0]  MAC_A = 48'h00AABBCCDDEE;
  localparam logic [127:0] IP4_A = 128'h0A010203;
  localparam logic [127:0] IP6_A = 128'hFE800000000000000000000000000002;

  task automatic chk(input string tag, input string what, input logic [127:0] got, input logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic bq_t mk(input logic [47:0] mac, input logic [15:0] et, input logic [7:0] ipb0,
                             input logic [7:0] l4, input logic [127:0] ip, input logic [15:0] port,
                             input logic [15:0] magic, input logic [7:0] ver, input logic [7:0] lbp,
                             input logic [63:0] tick, input int pay);
    bq_t f;
    int hl;
    logic [7:0] b;
    for (int i = 0; i < 6; i++) f.push_back(mac[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) f.push_back(8'h02 + 8'(i));
    f.push_back(et[15:8]); f.push_back(et[7:0]);
    if (et == 16'h86DD) begin
      for (int j = 0; j < 40; j++) begin
        b = 8'hA0 + 8'(j);
        if (j == 0) b = ipb0;
        if (j == 6) b = l4;
        if (j >= 24) b = ip[127-8*(j-24) -: 8];
        f.push_back(b);
      end
    end else begin
      hl = (ipb0[3:0] < 4'd5) ? 20 : 4 * int'(ipb0[3:0]);
      for (int j = 0; j < hl; j++) begin
        b = 8'h30 + 8'(j);
        if (j == 0) b = ipb0;
        if (j == 9) b = l4;
        if (j >= 16 && j < 20) b = ip[31-8*(j-16) -: 8];
        f.push_back(b);
      end
    end
    f.push_back(8'hC3); f.push_back(8'h50);
    f.push_back(port[15:8]); f.push_back(port[7:0]);
    f.push_back(8'h00); f.push_back(8'h40); f.push_back(8'h12); f.push_back(8'h34);
    f.push_back(magic[15:8]); f.push_back(magic[7:0]); f.push_back(ver); f.push_back(lbp);
    for (int i = 0; i < 8; i++) f.push_back(tick[63-8*i -: 8]);
    for (int i = 0; i < pay; i++) f.push_back(8'(i * 7 + 1));
    return f;
  endfunction

  function automatic void model(input bq_t f);
    int n, ip0, ud, lb, ihl;
    logic [15:0] et;
    n = f.size(); m_acc = 0; m_idx = n - 1;
    if (n < 14) return;
    et = {f[12], f[13]};
    if (et != 16'h0800 && et != 16'h86DD) begin m_idx = 13; return; end
    ip0 = 14;
    if (n <= ip0) return;
    if (et == 16'h0800) begin
      if (f[ip0][7:4] != 4'h4 || f[ip0][3:0] < 4'h5) begin m_idx = ip0; return; end
      if (n <= ip0 + 9) return;
      if (f[ip0+9] != 8'd17) begin m_idx = ip0 + 9; return; end
      ihl = int'(f[ip0][3:0]);
      ud = ip0 + 4 * ihl;
    end else begin
      if (f[ip0][7:4] != 4'h6) begin m_idx = ip0; return; end
      if (n <= ip0 + 6) return;
      if (f[ip0+6] != 8'd17) begin m_idx = ip0 + 6; return; end
      ud = ip0 + 40;
    end
    if (n <= ud + 3) return;
    if ({f[ud+2], f[ud+3]} != 16'h4C42) begin m_idx = ud + 3; return; end
    lb = ud + 8;
    if (n <= lb + 1) return;
    if ({f[lb], f[lb+1]} != 16'h4C42) begin m_idx = lb + 1; return; end
    if (n <= lb + 2) return;
    if (f[lb+2] != 8'd1) begin m_idx = lb + 2; return; end
    if (n <= lb + 11) return;
    m_idx = lb + 11;
    m_ip = '0;
    if (et == 16'h0800) for (int i = 0; i < 4; i++) m_ip = {m_ip[119:0], f[ip0+16+i]};
    else for (int i = 0; i < 16; i++) m_ip = {m_ip[119:0], f[ip0+24+i]};
    m_tick = '0;
    for (int i = 0; i < 8; i++) m_tick = {m_tick[55:0], f[lb+4+i]};
    m_et = et; m_proto = f[lb+3];
    for (int e = 0; e < 32; e++)
      if (t_vld[e] && t_mac[e] == {f[0], f[1], f[2], f[3], f[4], f[5]} && t_et[e] == et && t_ip[e] == m_ip)
        m_acc = 1;
  endfunction

  task automatic step(input logic v, input logic [7:0] b, input logic l, input bit ed, input string tag);
    byte_vld = v; byte_d = b; byte_last = l;
    @(posedge clk); #1;
    byte_vld = 0; byte_last = 0;
    chk(tag, "dec_vld", 128'(dec_vld), 128'(ed));
    if (ed) begin
      chk(tag, "accept", 128'(dec_acc), 128'(m_acc));
      if (m_acc) begin
        chk(tag, "tick", 128'(dec_tick), 128'(m_tick));
        chk(tag, "ip", dec_ip, m_ip);
        chk(tag, "etype", 128'(dec_et), 128'(m_et));
        chk(tag, "proto", 128'(dec_proto), 128'(m_proto));
      end
    end
  endtask

  task automatic send(input bq_t f, input string tag);
    model(f);
    for (int k = 0; k < f.size(); k++) begin
      gap_ctr++;
      if (gap_ctr % 7 == 3) step(0, 8'h00, 0, 0, tag);
      step(1, f[k], k == f.size() - 1, k == m_idx, tag);
    end
  endtask

  task automatic cfg(input int idx, input bit en, input logic [47:0] mac, input logic [15:0] et, input logic [127:0] ip);
    cfg_we = 1; cfg_idx = 5'(idx); cfg_en = en; cfg_mac = mac; cfg_et = et; cfg_ip = ip;
    @(posedge clk); #1;
    cfg_we = 0;
    t_vld[idx] = en; t_mac[idx] = mac; t_et[idx] = et; t_ip[idx] = ip;
  endtask

  function automatic bq_t v4(input logic [7:0] b0, input logic [7:0] l4, input logic [15:0] port,
                             input logic [15:0] mg, input logic [7:0] ver, input int pay);
    return mk(MAC_A, 16'h0800, b0, l4, IP4_A, port, mg, ver, 8'h01, 64'h0123456789ABCDEF, pay);
  endfunction

  initial begin
    bq_t f;
    for (int e = 0; e < 32; e++) t_vld[e] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "dec_vld in reset", 128'(dec_vld), 128'(0));
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1", "dec_vld after reset", 128'(dec_vld), 128'(0));
    chk("R1", "accept after reset", 128'(dec_acc), 128'(0));
    send(v4(8'h45, 8'd17, 16'h4C42, 16'h4C42, 8'd1, 8), "R1 empty table");

    cfg(3, 1, MAC_A, 16'h0800, IP4_A);
    cfg(9, 1, MAC_A, 16'h86DD, IP6_A);
    send(v4(8'h45, 8'd17, 16'h4C42, 16'h4C42, 8'd1, 20), "R12 v4 accept");
    send(v4(8'h47, 8'd17, 16'h4C42, 16'h4C42, 8'd1, 5), "R3 options");
    send(v4(8'h4F, 8'd17, 16'h4C42, 16'h4C42, 8'd1, 3), "R3 max options");
    send(v4(8'h44, 8'd17, 16'h4C42, 16'h4C42, 8'd1, 5), "R3 short ihl");
    send(v4(8'h55, 8'd17, 16'h4C42, 16'h4C42, 8'd1, 5), "R3 bad version");
    send(mk(MAC_A, 16'h86DD, 8'h60, 8'd17, IP6_A, 16'h4C42, 16'h4C42, 8'd1, 8'h07, 64'hFEDCBA9876543210, 10), "R4 v6 accept");
    send(mk(MAC_A, 16'h86DD, 8'h40, 8'd17, IP6_A, 16'h4C42, 16'h4C42, 8'd1, 8'h07, 64'h1, 10), "R4 v6 version");
    send(v4(8'h45, 8'd6, 16'h4C42, 16'h4C42, 8'd1, 5), "R5 v4 proto");
    send(mk(MAC_A, 16'h86DD, 8'h60, 8'd6, IP6_A, 16'h4C42, 16'h4C42, 8'd1, 8'h07, 64'h2, 4), "R5 v6 next header");
    send(v4(8'h45, 8'd17, 16'h4C43, 16'h4C42, 8'd1, 5), "R6 port");
    send(v4(8'h45, 8'd17, 16'h4C42, 16'h4C41, 8'd1, 5), "R7 magic");
    send(v4(8'h45, 8'd17, 16'h4C42, 16'h4C42, 8'd0, 5), "R7 version 0");
    send(v4(8'h45, 8'd17, 16'h4C42, 16'h4C42, 8'd2, 5), "R7 version 2");
    send(mk(MAC_A, 16'h0806, 8'h45, 8'd17, IP4_A, 16'h4C42, 16'h4C42, 8'd1, 8'h01, 64'h3, 4), "R2 other ethertype");
    send(mk(48'h00AABBCCDDEF, 16'h0800, 8'h45, 8'd17, IP4_A, 16'h4C42, 16'h4C42, 8'd1, 8'h01, 64'h4, 4), "R8 mac miss");
    send(mk(MAC_A, 16'h0800, 8'h45, 8'd17, 128'h0A010204, 16'h4C42, 16'h4C42, 8'd1, 8'h01, 64'h5, 4), "R8 ip miss");
    cfg(5, 1, MAC_A, 16'h0800, {96'h1, 32'h0A010205});
    send(mk(MAC_A, 16'h0800, 8'h45, 8'd17, 128'h0A010205, 16'h4C42, 16'h4C42, 8'd1, 8'h01, 64'h6, 4), "R8 zero extension");

    f = v4(8'h45, 8'd17, 16'h4C42, 16'h4C42, 8'd1, 0);
    send(f, "R10 ends at header end");
    f = f[0:29];
    send(f, "R10 truncated");
    f = f[0:13];
    send(f, "R10 truncated at ethertype");
    f = f[0:0];
    send(f, "R10 one byte");

    send(v4(8'h45, 8'd17, 16'h4C42, 16'h4C42, 8'd1, 64), "R11 long payload");
    send(v4(8'h45, 8'd17, 16'h4C43, 16'h4C42, 8'd1, 40), "R11 skip after drop");
    send(mk(MAC_A, 16'h86DD, 8'h60, 8'd17, IP6_A, 16'h4C42, 16'h4C42, 8'd1, 8'h22, 64'h8000000000000001, 0), "R11 back to back");

    cfg(3, 0, MAC_A, 16'h0800, IP4_A);
    send(v4(8'h45, 8'd17, 16'h4C42, 16'h4C42, 8'd1, 4), "R9 cleared entry");
    cfg(31, 1, MAC_A, 16'h0800, IP4_A);
    send(v4(8'h45, 8'd17, 16'h4C42, 16'h4C42, 8'd1, 4), "R9 other index");

    repeat (2) step(0, 8'h00, 0, 0, "R11 idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule